// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host-to-PCI bridge. A byte-wide port reads any location combinationally and writes one location per rising clock edge while the write strobe is high. Every location has a write rule of its own. The four identification bytes cannot be written. A few control registers keep only some of the written bits. The remaining locations keep the whole byte.

After reset the file holds fixed identification and class values and zeros elsewhere. The stored cache-control byte, the shadow segment byte and the shadow attribute byte are driven out continuously for downstream logic. A separate cache-enable bit is also driven out. A small two-state machine tells the shadow decoder that its settings changed. It sits in SHD_IDLE until a write reaches either shadow register. That write moves it to SHD_NOTIFY, where it stays for exactly one cycle and raises the refresh pulse. From SHD_NOTIFY it goes back to SHD_IDLE, or stays in SHD_NOTIFY if the next cycle is also a shadow write.

Top module: `nb_cfg_space`

## Requirements
- R1: After reset, bytes 0x00..0x03 read 0x60, 0x10, 0x81, 0x88 (vendor 0x1060, device 0x8881, little-endian).
- R2: After reset, byte 0x08 reads 0x01, bytes 0x09 and 0x0A read 0x00, byte 0x0B reads 0x06, and every other byte reads 0x00.
- R3: Writes to addresses 0x00..0x03 leave those bytes unchanged.
- R4: A write to 0x50 stores the data bits 7..3 and forces bits 2..0 to 3'b100 (512 KB cache size).
- R5: cache_enable equals bit 7 of byte 0x50. After a write to 0x50 it takes the new value in the cycle following that clock edge.
- R6: A write to 0x54 stores data bits 7..1 and always stores bit 0 as 0.
- R7: A write to 0x55 stores all eight data bits.
- R8: A write to 0x60 stores data & 0x3F, and a write to 0x61 stores data & 0x0F. Masked bits read as 0.
- R9: A write to any other address from 0x04 to 0xFF stores the full byte.
- R10: cfg_rdata shows the byte at cfg_addr in the same cycle. A read has no side effect, and nothing changes while cfg_we is low.
- R11: shadow_refresh is high for exactly the one cycle after each clock edge that captures a write to 0x54 or 0x55. It is low at all other times.
- R12: cache_ctrl, shadow_seg and shadow_attr always equal the stored bytes 0x50, 0x54 and 0x55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Byte at cfg_addr |
| cache_ctrl | output | 8 | Stored byte 0x50 |
| shadow_seg | output | 8 | Stored byte 0x54 |
| shadow_attr | output | 8 | Stored byte 0x55 |
| cache_enable | output | 1 | Bit 7 of byte 0x50 |
| shadow_refresh | output | 1 | One-cycle pulse after a shadow register write |

## Verification
All-ones and all-zeros writes to every masked register show whether each mask keeps the right bits and forces the right constant, including the forced 3'b100 cache-size field. Random addresses and data over the whole space, checked against a bench model, tell a wrong address decode apart from a wrong mask. Writes to the identification bytes and cycles with the strobe low but data present show that nothing is stored where it must not be. Back-to-back writes to the two shadow registers, each followed by writes elsewhere, show whether the refresh pulse lasts one cycle and repeats.

// File: rtl/nbcfg_pkg.sv
package nbcfg_pkg;

    typedef enum logic [0:0] {
        SHD_IDLE   = 1'b0,
        SHD_NOTIFY = 1'b1
    } shd_state_e;

    localparam int ID_TOP      = 3;
    localparam int A_REVISION  = 8'h08;
    localparam int A_PROGIF    = 8'h09;
    localparam int A_SUBCLASS  = 8'h0A;
    localparam int A_BASECLASS = 8'h0B;
    localparam int A_CACHE     = 8'h50;
    localparam int A_SHSEG     = 8'h54;
    localparam int A_SHATTR    = 8'h55;
    localparam int A_TIMA      = 8'h60;
    localparam int A_TIMB      = 8'h61;

    localparam logic [2:0] CACHE_SIZE_CODE = 3'b100;
    localparam logic [7:0] TIMA_KEEP       = 8'h3F;
    localparam logic [7:0] TIMB_KEEP       = 8'h0F;
    localparam logic [7:0] SHSEG_KEEP      = 8'hFE;

    function automatic logic [7:0] power_on_value(input int idx);
        logic [7:0] v;
        case (idx)
            0:           v = 8'h60;
            1:           v = 8'h10;
            2:           v = 8'h81;
            3:           v = 8'h88;
            A_REVISION:  v = 8'h01;
            A_BASECLASS: v = 8'h06;
            default:     v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/nbcfg_wmask.sv
module nbcfg_wmask
    import nbcfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic              wr_go,
    output logic [DATA_W-1:0] wr_val
);
    logic writable;

    always_comb begin
        writable = (int'(addr) > ID_TOP);
        wr_go    = we && writable;
    end

    always_comb begin
        case (int'(addr))
            A_CACHE:  wr_val = {wdata[DATA_W-1:3], CACHE_SIZE_CODE};
            A_SHSEG:  wr_val = wdata & DATA_W'(SHSEG_KEEP);
            A_TIMA:   wr_val = wdata & DATA_W'(TIMA_KEEP);
            A_TIMB:   wr_val = wdata & DATA_W'(TIMB_KEEP);
            default:  wr_val = wdata;
        endcase
    end
endmodule

// File: rtl/nbcfg_store.sv
module nbcfg_store
    import nbcfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] tap_cache,
    output logic [DATA_W-1:0] tap_seg,
    output logic [DATA_W-1:0] tap_attr
);
    localparam int NUM_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
        localparam logic [DATA_W-1:0] MY_INIT = DATA_W'(power_on_value(i));
        logic hit;
        assign hit = wr_go && (addr == MY_ADDR);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[i] <= MY_INIT;
            else if (hit)
                cells[i] <= wr_val;
        end
    end

    always_comb begin
        rd_val    = cells[addr];
        tap_cache = cells[A_CACHE];
        tap_seg   = cells[A_SHSEG];
        tap_attr  = cells[A_SHATTR];
    end
endmodule

// File: rtl/nbcfg_shadow_fsm.sv
module nbcfg_shadow_fsm
    import nbcfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              refresh
);
    shd_state_e state_q, state_d;
    logic       shadow_hit;

    assign shadow_hit = we && ((int'(addr) == A_SHSEG) || (int'(addr) == A_SHATTR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SHD_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHD_IDLE:   state_d = shadow_hit ? SHD_NOTIFY : SHD_IDLE;
            SHD_NOTIFY: state_d = shadow_hit ? SHD_NOTIFY : SHD_IDLE;
            default:    state_d = SHD_IDLE;
        endcase
    end

    always_comb begin
        refresh = (state_q == SHD_NOTIFY);
    end
endmodule

// File: rtl/nb_cfg_space.sv
module nb_cfg_space
    import nbcfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_we,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] cache_ctrl,
    output logic [DATA_W-1:0] shadow_seg,
    output logic [DATA_W-1:0] shadow_attr,
    output logic              cache_enable,
    output logic              shadow_refresh
);
    logic              wr_go;
    logic [DATA_W-1:0] wr_val;

    nbcfg_wmask #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mask (
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .we     (cfg_we),
        .wr_go  (wr_go),
        .wr_val (wr_val)
    );

    nbcfg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .addr      (cfg_addr),
        .wr_val    (wr_val),
        .rd_val    (cfg_rdata),
        .tap_cache (cache_ctrl),
        .tap_seg   (shadow_seg),
        .tap_attr  (shadow_attr)
    );

    nbcfg_shadow_fsm #(.ADDR_W(ADDR_W)) u_shd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .refresh (shadow_refresh)
    );

    assign cache_enable = cache_ctrl[DATA_W-1];
endmodule

// File: rtl/nb_cfg_chk.sv
module nb_cfg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_addr,
    input logic [7:0] cfg_wdata,
    input logic       cfg_we,
    input logic [7:0] cfg_rdata,
    input logic [7:0] cache_ctrl,
    input logic [7:0] shadow_seg,
    input logic [7:0] shadow_attr,
    input logic       cache_enable,
    input logic       shadow_refresh
);
    logic shd_wr;
    assign shd_wr = cfg_we && (cfg_addr == 8'h54 || cfg_addr == 8'h55);

    // R1
    id_vendor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 8'h00) |-> (cfg_rdata == 8'h60));

    // R3
    id_device_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 8'h03) |-> (cfg_rdata == 8'h88));

    // R4
    cache_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h50) |=> (cache_ctrl == {$past(cfg_wdata[7:3]), 3'b100}));

    // R5
    cache_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h50) |=> (cache_enable == $past(cfg_wdata[7])));

    // R6
    seg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h54) |=> (shadow_seg == {$past(cfg_wdata[7:1]), 1'b0}));

    // R7
    attr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h55) |=> (shadow_attr == $past(cfg_wdata)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(cache_ctrl) && $stable(shadow_seg) && $stable(shadow_attr)));

    // R11
    refresh_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shd_wr |=> shadow_refresh);

    // R11
    refresh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shd_wr |=> !shadow_refresh);
endmodule

bind nb_cfg_space nb_cfg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_addr       (cfg_addr),
    .cfg_wdata      (cfg_wdata),
    .cfg_we         (cfg_we),
    .cfg_rdata      (cfg_rdata),
    .cache_ctrl     (cache_ctrl),
    .shadow_seg     (shadow_seg),
    .shadow_attr    (shadow_attr),
    .cache_enable   (cache_enable),
    .shadow_refresh (shadow_refresh)
);

// File: tb/sim_nb_cfg_space.sv
module sim_nb_cfg_space;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_rdata, cache_ctrl, shadow_seg, shadow_attr;
    logic       cache_enable, shadow_refresh;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [7:0] model [256];

    always #4 clk = ~clk;

    nb_cfg_space u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .cache_ctrl(cache_ctrl),
        .shadow_seg(shadow_seg), .shadow_attr(shadow_attr),
        .cache_enable(cache_enable), .shadow_refresh(shadow_refresh)
    );

    function automatic logic [7:0] exp_reset(input int a);
        case (a)
            0: return 8'h60;
            1: return 8'h10;
            2: return 8'h81;
            3: return 8'h88;
            8: return 8'h01;
            11: return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_store(input int a, input logic [7:0] d);
        case (a)
            8'h50: return {d[7:3], 3'b100};
            8'h54: return d & 8'hFE;
            8'h60: return d & 8'h3F;
            8'h61: return d & 8'h0F;
            default: return d;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, "/R12 cache_ctrl"}, cache_ctrl, model[8'h50]);
        check({req, "/R12 shadow_seg"}, shadow_seg, model[8'h54]);
        check({req, "/R12 shadow_attr"}, shadow_attr, model[8'h55]);
        check({req, "/R5 cache_enable"}, {7'd0, cache_enable}, {7'd0, model[8'h50][7]});
    endtask

    // drive a write, then sample one half cycle after the capturing edge
    task automatic do_write(input string req, input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = 8'(a); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a > 3) model[a] = exp_store(a, d);
        check({req, "/R11 refresh"}, {7'd0, shadow_refresh},
              {7'd0, (a == 8'h54 || a == 8'h55)});
        check_outputs(req);
    endtask

    task automatic do_read(input string req, input int a);
        @(negedge clk);
        cfg_addr = 8'(a); cfg_we = 1'b0;
        #1;
        check(req, cfg_rdata, model[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        for (int i = 0; i < 256; i++) model[i] = exp_reset(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 reset contents
        for (int i = 0; i < 256; i++) do_read((i < 4) ? "R1 reset id" : "R2 reset", i);
        check("R11 idle", {7'd0, shadow_refresh}, 8'd0);
        check_outputs("R2");

        // R3 identification bytes are read-only
        for (int i = 0; i < 4; i++) begin
            do_write("R3", i, 8'hFF);
            do_read("R3 id unchanged", i);
        end
        // R4 R5 cache register
        do_write("R4", 8'h50, 8'h00); do_read("R4 zero write", 8'h50);
        do_write("R4", 8'h50, 8'hFF); do_read("R4 ones write", 8'h50);
        do_write("R5", 8'h50, 8'h7B); do_read("R5 disable", 8'h50);
        // R6 R7 shadow registers, back to back
        do_write("R6", 8'h54, 8'hFF); do_read("R6 bit0 zero", 8'h54);
        do_write("R7", 8'h55, 8'hA5);
        do_write("R7", 8'h54, 8'h01);
        do_write("R11 after shadow", 8'h56, 8'h11);
        do_read("R7 full", 8'h55);
        // R8 timing masks
        do_write("R8", 8'h60, 8'hFF); do_read("R8 mask3F", 8'h60);
        do_write("R8", 8'h61, 8'hFF); do_read("R8 mask0F", 8'h61);
        // R9 edge addresses
        do_write("R9", 8'h04, 8'h5A); do_read("R9 low", 8'h04);
        do_write("R9", 8'hFF, 8'hC3); do_read("R9 top", 8'hFF);
        // R10 strobe low with data present
        @(negedge clk);
        cfg_addr = 8'h50; cfg_wdata = 8'hFF; cfg_we = 1'b0;
        @(negedge clk);
        check("R10 no strobe", cfg_rdata, model[8'h50]);
        check_outputs("R10");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int a;
            logic [7:0] d;
            a = ($urandom % 4 == 0) ? (8'h50 + ($urandom % 18)) : int'($urandom % 256);
            d = 8'($urandom);
            if ($urandom % 2 == 0) do_write("R9 random", a, d);
            do_read("R10 random", int'($urandom % 256));
        end
        for (int i = 0; i < 256; i++) do_read("R10 final", i);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule